// File: doc/BRIEF.md
# Serial Receiver with Request-to-Send Pacing

This block turns an asynchronous serial line into parallel characters and queues them in a receive FIFO. A frame starts with a low start bit. It then carries 7 or 8 data bits, least significant bit first, an optional parity bit and one or two stop bits. The line is oversampled by an enable tick that runs at sixteen times the bit rate. Each bit is sampled once, in the middle of its sixteen ticks.

Every queued entry carries its character together with three tags: parity error, framing error and break. A consumer pulls entries with a pop strobe, and the tags appear with the character they belong to. The block paces the remote transmitter with an active-low request-to-send output, which it derives from the FIFO level and a trigger level. It raises a DMA request when the level reaches a watermark. It pulses an overrun flag when a complete character arrives and there is no room for it.

Top module: `uart_rx_flow`

## Requirements
- R1: In 8-bit mode the received bits, first bit into bit 0, are read back unchanged in `rd_data`, with one or two stop bits as selected by `cfg_stop2`.
- R2: In 7-bit mode (`cfg_data8`=0) seven data bits are taken and `rd_data[7]` reads 0.
- R3: With `cfg_par_en`=1, a parity bit follows the data. With `cfg_par_odd`=1 the ones in data plus parity must be odd, otherwise even. On a mismatch `rd_perr`=1 for that entry, and the flag appears only when that entry is popped.
- R4: A first or second stop bit sampled low sets `rd_ferr` for that entry.
- R5: A frame whose every sample, stop bits included, is low is queued once with `rd_brk`=1 and data 0. No further frame is started until the line returns high.
- R6: `overrun` pulses for one cycle only when a complete character arrives while the FIFO holds `DEPTH` (16) entries and no pop happens. That character is dropped and the stored entries stay intact.
- R7: `rts_n` is 0 while `level` < `trig_lvl` and 1 while `level` >= `trig_lvl`, one cycle after `level`.
- R8: `dma_req` is 1 exactly when `level` >= `wmark`, one cycle after `level`.
- R9: A start bit that reads high at its middle sample is rejected, and nothing is queued.
- R10: A pop on a non-empty FIFO yields `rd_valid`=1 with the oldest entry on the next cycle. A pop on an empty FIFO is ignored: `rd_valid` stays 0 and `level` stays 0.
- R11: After reset `level`=0, `rts_n`=0, `dma_req`=0, `overrun`=0 and `rd_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_in | input | 1 | Serial line, idle high |
| os_tick | input | 1 | Oversample enable, 16 per bit |
| cfg_data8 | input | 1 | 1: 8 data bits, 0: 7 |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1: odd parity, 0: even |
| cfg_stop2 | input | 1 | 1: two stop bits |
| pop | input | 1 | Read strobe for the oldest entry |
| trig_lvl | input | 5 | Level at which `rts_n` rises |
| wmark | input | 5 | Level at which `dma_req` rises |
| rd_data | output | 8 | Character of the popped entry |
| rd_perr | output | 1 | Parity error tag of the popped entry |
| rd_ferr | output | 1 | Framing error tag of the popped entry |
| rd_brk | output | 1 | Break tag of the popped entry |
| rd_valid | output | 1 | Popped entry is on the read outputs |
| level | output | 5 | Number of stored entries |
| rts_n | output | 1 | Request-to-send, active low |
| dma_req | output | 1 | Level at or above the watermark |
| overrun | output | 1 | One-cycle pulse for a dropped character |

## Verification
The assertions assume that `trig_lvl` and `wmark` are at least 1, so the reset values of `rts_n` and `dma_req` agree with an empty FIFO. They also assume that configuration inputs stay still while a frame is on the line. The bench sets the configuration only between frames and never programs a zero threshold. It drives the serial line only on falling clock edges, with bit cells exactly sixteen ticks long.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef struct packed {
    logic       brk;
    logic       ferr;
    logic       perr;
    logic [7:0] data;
  } rx_entry_t;

  localparam int ENTRY_W = $bits(rx_entry_t);
endpackage

// File: rtl/rx_deser.sv
module rx_deser
  import uart_rx_pkg::*;
#(
  parameter int OS = 16
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      rx_in,
  input  logic      tick,
  input  logic      data8,
  input  logic      par_en,
  input  logic      par_odd,
  input  logic      stop2,
  output logic      push,
  output rx_entry_t entry
);
  localparam int TW   = $clog2(OS);
  localparam int MID  = OS / 2 - 1;
  localparam int LAST = OS - 1;

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP1, S_STOP2, S_HOLD} st_t;

  st_t           st;
  logic [1:0]    sync;
  logic [TW-1:0] tcnt;
  logic [2:0]    bitn;
  logic [7:0]    sreg;
  logic          pbit, zero, ferr;
  logic          rxs, samp, fin_ferr, fin_zero;
  logic [7:0]    dval;

  assign rxs      = sync[1];
  assign samp     = tick && (tcnt == TW'(LAST));
  assign fin_ferr = ferr | ~rxs;
  assign fin_zero = zero & ~rxs;
  assign dval     = data8 ? sreg : {1'b0, sreg[7:1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= S_IDLE;
      sync  <= 2'b11;
      tcnt  <= '0;
      bitn  <= '0;
      sreg  <= '0;
      pbit  <= 1'b0;
      zero  <= 1'b0;
      ferr  <= 1'b0;
      push  <= 1'b0;
      entry <= '0;
    end else begin
      push <= 1'b0;
      sync <= {sync[0], rx_in};
      if (tick && st != S_IDLE && st != S_START && st != S_HOLD)
        tcnt <= samp ? '0 : tcnt + 1'b1;
      case (st)
        S_IDLE: if (tick && !rxs) begin
          st   <= S_START;
          tcnt <= '0;
        end
        S_START: if (tick) begin
          if (tcnt == TW'(MID)) begin
            tcnt <= '0;
            if (rxs) st <= S_IDLE;
            else begin
              st   <= S_DATA;
              bitn <= '0;
              zero <= 1'b1;
              ferr <= 1'b0;
              pbit <= 1'b0;
            end
          end else tcnt <= tcnt + 1'b1;
        end
        S_DATA: if (samp) begin
          sreg <= {rxs, sreg[7:1]};
          if (rxs) zero <= 1'b0;
          if (bitn == (data8 ? 3'd7 : 3'd6)) st <= par_en ? S_PAR : S_STOP1;
          else bitn <= bitn + 1'b1;
        end
        S_PAR: if (samp) begin
          pbit <= rxs;
          if (rxs) zero <= 1'b0;
          st <= S_STOP1;
        end
        S_STOP1, S_STOP2: if (samp) begin
          if (st == S_STOP1 && stop2) begin
            ferr <= fin_ferr;
            zero <= fin_zero;
            st   <= S_STOP2;
          end else begin
            push       <= 1'b1;
            entry.data <= dval;
            entry.perr <= par_en & (^dval ^ pbit ^ par_odd);
            entry.ferr <= fin_ferr;
            entry.brk  <= fin_zero;
            st         <= fin_zero ? S_HOLD : S_IDLE;
          end
        end
        S_HOLD: if (rxs) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rx_fifo.sv
module rx_fifo #(
  parameter int W     = 11,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [W-1:0]  wr_data,
  input  logic          rd_en,
  output logic [W-1:0]  rd_data,
  output logic          rd_valid,
  output logic [CW-1:0] count,
  output logic          drop
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          full, empty, do_wr, do_rd;

  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);
  assign do_rd = rd_en && !empty;
  assign do_wr = wr_en && (!full || do_rd);
  assign drop  = wr_en && full && !do_rd;

  always_ff @(posedge clk) begin
    if (do_wr) mem[wptr] <= wr_data;
    if (do_rd) rd_data <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr     <= '0;
      rptr     <= '0;
      count    <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= do_rd;
      if (do_wr) wptr <= wptr + 1'b1;
      if (do_rd) rptr <= rptr + 1'b1;
      case ({do_wr, do_rd})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/uart_rx_flow.sv
module uart_rx_flow
  import uart_rx_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int OS    = 16,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rx_in,
  input  logic          os_tick,
  input  logic          cfg_data8,
  input  logic          cfg_par_en,
  input  logic          cfg_par_odd,
  input  logic          cfg_stop2,
  input  logic          pop,
  input  logic [CW-1:0] trig_lvl,
  input  logic [CW-1:0] wmark,
  output logic [7:0]    rd_data,
  output logic          rd_perr,
  output logic          rd_ferr,
  output logic          rd_brk,
  output logic          rd_valid,
  output logic [CW-1:0] level,
  output logic          rts_n,
  output logic          dma_req,
  output logic          overrun
);
  logic      push, drop;
  rx_entry_t in_e, out_e;

  rx_deser #(.OS(OS)) i_deser (
    .clk(clk), .rst(rst), .rx_in(rx_in), .tick(os_tick),
    .data8(cfg_data8), .par_en(cfg_par_en), .par_odd(cfg_par_odd),
    .stop2(cfg_stop2), .push(push), .entry(in_e)
  );

  rx_fifo #(.W(ENTRY_W), .DEPTH(DEPTH)) i_fifo (
    .clk(clk), .rst(rst), .wr_en(push), .wr_data(in_e),
    .rd_en(pop), .rd_data(out_e), .rd_valid(rd_valid),
    .count(level), .drop(drop)
  );

  assign rd_data = out_e.data;
  assign rd_perr = out_e.perr;
  assign rd_ferr = out_e.ferr;
  assign rd_brk  = out_e.brk;

  always_ff @(posedge clk) begin
    if (rst) begin
      rts_n   <= 1'b0;
      dma_req <= 1'b0;
      overrun <= 1'b0;
    end else begin
      rts_n   <= (level >= trig_lvl);
      dma_req <= (level >= wmark);
      overrun <= drop;
    end
  end
endmodule

// File: rtl/uart_rx_flow_chk.sv
module uart_rx_flow_chk #(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst,
  input logic          pop,
  input logic [CW-1:0] trig_lvl,
  input logic [CW-1:0] wmark,
  input logic [CW-1:0] level,
  input logic          rts_n,
  input logic          dma_req,
  input logic          overrun,
  input logic          rd_valid
);
  AST_LEVEL_MAX: assert property (@(posedge clk) disable iff (rst) level <= CW'(DEPTH)); // R6
  AST_OVR_AT_FULL: assert property (@(posedge clk) disable iff (rst) overrun |-> $past(level) == CW'(DEPTH)); // R6
  AST_OVR_KEEPS: assert property (@(posedge clk) disable iff (rst) overrun |-> level == $past(level)); // R6
  AST_RTS_TRIG: assert property (@(posedge clk) disable iff (rst) rts_n == ($past(level) >= $past(trig_lvl))); // R7
  AST_DMA_WMARK: assert property (@(posedge clk) disable iff (rst) dma_req == ($past(level) >= $past(wmark))); // R8
  AST_RD_NONEMPTY: assert property (@(posedge clk) disable iff (rst) rd_valid |-> ($past(pop) && $past(level) != '0)); // R10
  AST_EMPTY_POP: assert property (@(posedge clk) disable iff (rst) (pop && level == '0) |=> !rd_valid); // R10
endmodule

bind uart_rx_flow uart_rx_flow_chk #(.DEPTH(DEPTH)) i_chk (
  .clk(clk), .rst(rst), .pop(pop), .trig_lvl(trig_lvl), .wmark(wmark),
  .level(level), .rts_n(rts_n), .dma_req(dma_req), .overrun(overrun),
  .rd_valid(rd_valid)
);

// File: tb/test_uart_rx_flow.sv
module test_uart_rx_flow;
  localparam int CLK_PERIOD = 10;
  localparam int TD = 2;
  localparam int BT = 16 * TD;

  logic clk = 0, rst = 1, rx_in = 1, os_tick = 0;
  logic cfg_data8 = 1, cfg_par_en = 0, cfg_par_odd = 0, cfg_stop2 = 0, pop = 0;
  logic [4:0] trig_lvl = 5'd16, wmark = 5'd16;
  logic [7:0] rd_data;
  logic rd_perr, rd_ferr, rd_brk, rd_valid, rts_n, dma_req, overrun;
  logic [4:0] level;
  int n_chk = 0, n_bad = 0, ovr_cnt = 0, div = 0;

  uart_rx_flow i_uart_rx_flow (.*);

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) begin
    div     <= (div == TD-1) ? 0 : div + 1;
    os_tick <= (div == TD-1);
  end
  always @(negedge clk) if (!rst && overrun) ovr_cnt++;

  task automatic chk(string req, int got, int exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic bitcell(logic v, int n = 1);
    rx_in = v;
    repeat (n*BT) @(negedge clk);
  endtask

  task automatic send(logic [7:0] d, bit flip_par = 0, bit bad_stop = 0);
    logic [7:0] dm;
    logic p;
    dm = cfg_data8 ? d : {1'b0, d[6:0]};
    p = (^dm) ^ cfg_par_odd ^ flip_par;
    @(negedge clk);
    bitcell(0);
    for (int i = 0; i < (cfg_data8 ? 8 : 7); i++) bitcell(dm[i]);
    if (cfg_par_en) bitcell(p);
    bitcell(~bad_stop);
    if (cfg_stop2) bitcell(1);
    bitcell(1);
  endtask

  task automatic rd(string req, logic [7:0] d, bit pe, bit fe, bit bk);
    @(negedge clk); pop = 1;
    @(negedge clk); pop = 0;
    chk({req, " valid"}, rd_valid, 1);
    chk({req, " data"}, rd_data, d);
    chk({req, " perr"}, rd_perr, pe);
    chk({req, " ferr"}, rd_ferr, fe);
    chk({req, " brk"}, rd_brk, bk);
  endtask

  task automatic cfg(bit d8, bit pe, bit po, bit s2);
    cfg_data8 = d8; cfg_par_en = pe; cfg_par_odd = po; cfg_stop2 = s2;
  endtask

  task automatic t_reset;
    chk("R11 level", level, 0);
    chk("R11 rts_n", rts_n, 0);
    chk("R11 dma_req", dma_req, 0);
    chk("R11 overrun", overrun, 0);
    chk("R11 rd_valid", rd_valid, 0);
  endtask

  task automatic t_basic;
    cfg(1, 0, 0, 0); send(8'hA5);
    cfg(1, 0, 0, 1); send(8'h3C);
    chk("R1 level", level, 2);
    rd("R1 a5", 8'hA5, 0, 0, 0);
    rd("R1 3c two stop", 8'h3C, 0, 0, 0);
  endtask

  task automatic t_seven;
    cfg(0, 1, 0, 0); send(8'hD5);
    rd("R2 seven-bit", 8'h55, 0, 0, 0);
  endtask

  task automatic t_parity;
    cfg(1, 1, 1, 0); send(8'h81);
    cfg(1, 1, 0, 0); send(8'h07, 1);
    cfg(1, 1, 1, 1); send(8'h10, 1);
    chk("R3 no flag on arrival", rd_perr, 0);
    rd("R3 odd ok", 8'h81, 0, 0, 0);
    rd("R3 even bad", 8'h07, 1, 0, 0);
    rd("R3 odd bad", 8'h10, 1, 0, 0);
  endtask

  task automatic t_frame;
    cfg(1, 0, 0, 0); send(8'h5A, 0, 1);
    rd("R4 bad stop", 8'h5A, 0, 1, 0);
  endtask

  task automatic t_break;
    cfg(1, 0, 0, 0);
    @(negedge clk);
    bitcell(0, 14);
    bitcell(1, 2);
    chk("R5 one entry", level, 1);
    rd("R5 break", 8'h00, 0, 1, 1);
  endtask

  task automatic t_glitch;
    @(negedge clk);
    rx_in = 0; repeat (3*TD) @(negedge clk);
    bitcell(1, 12);
    chk("R9 glitch dropped", level, 0);
  endtask

  task automatic t_empty_pop;
    @(negedge clk); pop = 1;
    @(negedge clk); pop = 0;
    chk("R10 empty pop valid", rd_valid, 0);
    chk("R10 empty pop level", level, 0);
  endtask

  task automatic t_flow;
    trig_lvl = 5'd3; wmark = 5'd2;
    cfg(1, 0, 0, 0);
    send(8'h01);
    chk("R7 rts low at 1", rts_n, 0);
    chk("R8 dma low at 1", dma_req, 0);
    send(8'h02);
    chk("R8 dma high at 2", dma_req, 1);
    chk("R7 rts low at 2", rts_n, 0);
    send(8'h03);
    chk("R7 rts high at 3", rts_n, 1);
    rd("R7 pop", 8'h01, 0, 0, 0);
    @(negedge clk);
    chk("R7 rts low after pop", rts_n, 0);
    rd("R8 pop", 8'h02, 0, 0, 0);
    @(negedge clk);
    chk("R8 dma low after pop", dma_req, 0);
    rd("R8 drain", 8'h03, 0, 0, 0);
    trig_lvl = 5'd16; wmark = 5'd16;
  endtask

  task automatic t_overrun;
    int base;
    cfg(1, 0, 0, 0);
    base = ovr_cnt;
    for (int i = 0; i < 16; i++) send(8'(i*7+1));
    chk("R6 no overrun at 16", ovr_cnt - base, 0);
    send(8'hEE);
    chk("R6 overrun pulse", ovr_cnt - base, 1);
    chk("R6 level kept", level, 16);
    for (int i = 0; i < 16; i++) rd("R6 preserved", 8'(i*7+1), 0, 0, 0);
    chk("R6 extra dropped", level, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset;
    t_basic;
    t_seven;
    t_parity;
    t_frame;
    t_break;
    t_glitch;
    t_empty_pop;
    t_flow;
    t_overrun;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule